// File: doc/BRIEF.md
# Multi-Source Programmable Output Divider

This block turns a small set of fast source clocks into a bank of slower output clocks. Each source is not a real clock here. It is a pair of single-cycle strobes on one fast system clock: one strobe marks the source's rising edge and the other marks its falling edge. Four general outputs, one processor output and one auxiliary output each divide a chosen source by a ratio taken from a fixed and irregular set. Each output gives a toggling level and a one-cycle strobe at the start of every output period.

Configuration arrives as one register image, applied by a write pulse. Each general output takes a source select and a ratio index. The processor output takes a source select and a small code that offers only divide-by-1, 2 or 4. The auxiliary output is tied to one fixed source and takes a ratio index only. Odd ratios keep a near-even duty cycle because the high phase ends on a source falling edge. Outputs that share a source start their periods together after each configuration write.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset all levels and strobes are 0. Every path divides by 1 and every general and processor path uses source 0.
- R2: Ratio index values 0 to 17 select, in rising order, 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96 and 104. An index of 18 or more is rejected and the path keeps its previous ratio. Image layout: general output i has its source select in bits [7i+1:7i] and its index in bits [7i+6:7i+2]. The processor select is in [29:28] and its code in [31:30]. The auxiliary index is in [36:32].
- R3: A path's strobe is high for one cycle, in the cycle after a source rising edge that begins an output period. The first rising edge after a restart begins a period, and then every N-th rising edge begins one.
- R4: For an even ratio N, the level goes high at the rising edge that begins a period and low at the rising edge N/2 later.
- R5: For an odd ratio N, the level goes high at the rising edge that begins a period. It goes low at the falling edge that follows rising edge (N-1)/2 of the period, so it stays high for N of the 2N source half-cycles.
- R6: A configuration write restarts every general and processor divider. Their levels are 0 in the next cycle, and source edges in the write cycle are ignored by them. General outputs with the same source and ratio then carry identical levels.
- R7: Processor codes 0, 1 and 2 select divide-by-1, 2 and 4. Code 3 is rejected and the previous ratio is kept.
- R8: A source select of NSRC or more is rejected and the previous source is kept. The ratio field of the same write is still applied.
- R9: The auxiliary path divides source AUX_SRC using the full ratio set. A write restarts it only when it carries a valid index that differs from the one in use. Otherwise the auxiliary path continues undisturbed.
- R10: An output level changes only in the cycle after an edge of its own source, or after a write that restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_rise | input | NSRC | Per-source rising-edge strobe |
| src_fall | input | NSRC | Per-source falling-edge strobe |
| cfg_wr | input | 1 | Apply cfg_img this cycle |
| cfg_img | input | 37 | Configuration image (layout in R2) |
| gen_lvl | output | NGEN | General output levels |
| gen_stb | output | NGEN | General output period strobes |
| cpu_lvl | output | 1 | Processor output level |
| cpu_stb | output | 1 | Processor output period strobe |
| aux_lvl | output | 1 | Auxiliary output level |
| aux_stb | output | 1 | Auxiliary output period strobe |

## Verification
The assertions assume that each source's strobes alternate between rising and falling, and that a source never raises both strobes in the same cycle. The strobe-implies-rising-level property depends on both assumptions. The bench keeps one next-edge flag per source and only ever emits that edge, so both the full-rate directed phases and the sparse random phase stay inside the assumptions. Rejected fields, odd ratios up to 104, and edges that arrive in a write cycle all come from the directed images and the random images.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int NRAT    = 18;
   localparam int IDX_W   = 5;
   localparam int RATIO_W = 7;
   localparam int CODE_W  = 2;

   function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] idx);
      logic [RATIO_W-1:0] r;
      case (idx)
         5'd0:    r = 7'd1;
         5'd1:    r = 7'd2;
         5'd2:    r = 7'd3;
         5'd3:    r = 7'd4;
         5'd4:    r = 7'd5;
         5'd5:    r = 7'd6;
         5'd6:    r = 7'd8;
         5'd7:    r = 7'd10;
         5'd8:    r = 7'd12;
         5'd9:    r = 7'd13;
         5'd10:   r = 7'd20;
         5'd11:   r = 7'd24;
         5'd12:   r = 7'd26;
         5'd13:   r = 7'd40;
         5'd14:   r = 7'd48;
         5'd15:   r = 7'd52;
         5'd16:   r = 7'd96;
         5'd17:   r = 7'd104;
         default: r = 7'd1;
      endcase
      return r;
   endfunction

   function automatic logic [RATIO_W-1:0] cpu_ratio_of(input logic [IDX_W-1:0] code);
      return RATIO_W'(1) << code[CODE_W-1:0];
   endfunction
endpackage

// File: rtl/clkdiv_srcmux.sv
module clkdiv_srcmux #(
   parameter int NSRC  = 3,
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [NSRC-1:0]  rise_v,
   input  logic [NSRC-1:0]  fall_v,
   output logic             rise,
   output logic             fall
);
   always_comb begin
      rise = 1'b0;
      fall = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
         if (sel == SEL_W'(s)) begin
            rise = rise_v[s];
            fall = fall_v[s];
         end
      end
   end
endmodule

// File: rtl/clkdiv_slot.sv
module clkdiv_slot
   import clkdiv_pkg::*;
#(
   parameter int NSRC     = 3,
   parameter int SEL_W    = 2,
   parameter bit CPU_PATH = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [SEL_W-1:0]   sel_in,
   input  logic [IDX_W-1:0]   code_in,
   output logic [SEL_W-1:0]   sel_q,
   output logic [RATIO_W-1:0] ratio_q
);
   logic               code_ok;
   logic [RATIO_W-1:0] ratio_new;
   logic               sel_ok;

   assign sel_ok = (32'(sel_in) < NSRC);

   generate
      if (CPU_PATH) begin : g_cpu
         assign code_ok   = (32'(code_in) < 3);
         assign ratio_new = cpu_ratio_of(code_in);
      end else begin : g_full
         assign code_ok   = (32'(code_in) < NRAT);
         assign ratio_new = ratio_of(code_in);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         ratio_q <= RATIO_W'(1);
      end else if (wr) begin
         if (sel_ok)  sel_q   <= sel_in;
         if (code_ok) ratio_q <= ratio_new;
      end
   end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
   parameter int RATIO_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               rise,
   input  logic               fall,
   input  logic [RATIO_W-1:0] ratio,
   output logic               lvl,
   output logic               stb
);
   logic [RATIO_W-1:0] ph_q;
   logic [RATIO_W-1:0] ph_nx;
   logic [RATIO_W-1:0] half;
   logic               run_q;
   logic               odd;

   // even N: low at rise N/2; odd N: low at fall after rise (N-1)/2 -- both N>>1
   assign half = ratio >> 1;
   assign odd  = ratio[0];

   always_comb begin
      if (!run_q || ph_q == ratio - RATIO_W'(1)) ph_nx = '0;
      else                                        ph_nx = ph_q + RATIO_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         run_q <= 1'b0;
         lvl   <= 1'b0;
         stb   <= 1'b0;
      end else if (restart) begin
         ph_q  <= '0;
         run_q <= 1'b0;
         lvl   <= 1'b0;
         stb   <= 1'b0;
      end else begin
         stb <= 1'b0;
         if (rise) begin
            ph_q  <= ph_nx;
            run_q <= 1'b1;
            stb   <= (ph_nx == '0);
            if (ph_nx == '0)               lvl <= 1'b1;
            else if (!odd && ph_nx == half) lvl <= 1'b0;
         end else if (fall && run_q && odd && ph_q == half) begin
            lvl <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
   import clkdiv_pkg::*;
#(
   parameter int NSRC    = 3,
   parameter int NGEN    = 4,
   parameter int AUX_SRC = 0,
   parameter int SEL_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
   parameter int CFG_W   = NGEN * (SEL_W + IDX_W) + SEL_W + CODE_W + IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_rise,
   input  logic [NSRC-1:0]  src_fall,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_img,
   output logic [NGEN-1:0]  gen_lvl,
   output logic [NGEN-1:0]  gen_stb,
   output logic             cpu_lvl,
   output logic             cpu_stb,
   output logic             aux_lvl,
   output logic             aux_stb
);
   localparam int GEN_FW  = SEL_W + IDX_W;
   localparam int CPU_LSB = NGEN * GEN_FW;
   localparam int AUX_LSB = CPU_LSB + SEL_W + CODE_W;

   if (NSRC < 2 || NGEN < 1 || AUX_SRC >= NSRC || AUX_SRC < 0
       || CFG_W != AUX_LSB + IDX_W) begin : g_bad_param
      $error("clkdiv_bank: illegal parameter set");
   end

   logic [NGEN-1:0][SEL_W-1:0]   gsel_q;
   logic [NGEN-1:0][RATIO_W-1:0] gratio_q;
   logic [SEL_W-1:0]             cpu_sel_q;
   logic [RATIO_W-1:0]           cpu_ratio_q;

   genvar g;
   generate
      for (g = 0; g < NGEN; g++) begin : g_out
         logic r_sel;
         logic f_sel;

         clkdiv_slot #(.NSRC(NSRC), .SEL_W(SEL_W), .CPU_PATH(1'b0)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (cfg_wr),
            .sel_in  (cfg_img[g*GEN_FW +: SEL_W]),
            .code_in (cfg_img[g*GEN_FW+SEL_W +: IDX_W]),
            .sel_q   (gsel_q[g]),
            .ratio_q (gratio_q[g])
         );

         clkdiv_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
            .sel    (gsel_q[g]),
            .rise_v (src_rise),
            .fall_v (src_fall),
            .rise   (r_sel),
            .fall   (f_sel)
         );

         clkdiv_core #(.RATIO_W(RATIO_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (cfg_wr),
            .rise    (r_sel),
            .fall    (f_sel),
            .ratio   (gratio_q[g]),
            .lvl     (gen_lvl[g]),
            .stb     (gen_stb[g])
         );
      end
   endgenerate

   // processor path: narrow code, zero-extended into the slot's index port
   logic cpu_r;
   logic cpu_f;

   clkdiv_slot #(.NSRC(NSRC), .SEL_W(SEL_W), .CPU_PATH(1'b1)) u_cpu_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .sel_in  (cfg_img[CPU_LSB +: SEL_W]),
      .code_in ({{(IDX_W-CODE_W){1'b0}}, cfg_img[CPU_LSB+SEL_W +: CODE_W]}),
      .sel_q   (cpu_sel_q),
      .ratio_q (cpu_ratio_q)
   );

   clkdiv_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_cpu_mux (
      .sel    (cpu_sel_q),
      .rise_v (src_rise),
      .fall_v (src_fall),
      .rise   (cpu_r),
      .fall   (cpu_f)
   );

   clkdiv_core #(.RATIO_W(RATIO_W)) u_cpu_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_wr),
      .rise    (cpu_r),
      .fall    (cpu_f),
      .ratio   (cpu_ratio_q),
      .lvl     (cpu_lvl),
      .stb     (cpu_stb)
   );

   // auxiliary path: fixed source, restarts only on a real ratio change
   logic [IDX_W-1:0] aux_idx_q;
   logic [IDX_W-1:0] aux_idx_in;
   logic             aux_restart;

   assign aux_idx_in  = cfg_img[AUX_LSB +: IDX_W];
   assign aux_restart = cfg_wr && (32'(aux_idx_in) < NRAT) && (aux_idx_in != aux_idx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           aux_idx_q <= '0;
      else if (aux_restart) aux_idx_q <= aux_idx_in;
   end

   clkdiv_core #(.RATIO_W(RATIO_W)) u_aux_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (aux_restart),
      .rise    (src_rise[AUX_SRC]),
      .fall    (src_fall[AUX_SRC]),
      .ratio   (ratio_of(aux_idx_q)),
      .lvl     (aux_lvl),
      .stb     (aux_stb)
   );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
   parameter int NSRC    = 3,
   parameter int NGEN    = 4,
   parameter int SEL_W   = 2,
   parameter int RATIO_W = 7
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NSRC-1:0]              src_rise,
   input logic [NSRC-1:0]              src_fall,
   input logic                         cfg_wr,
   input logic [NGEN-1:0]              gen_lvl,
   input logic [NGEN-1:0]              gen_stb,
   input logic                         cpu_lvl,
   input logic                         cpu_stb,
   input logic                         aux_lvl,
   input logic                         aux_stb,
   input logic [NGEN-1:0][SEL_W-1:0]   gsel,
   input logic [NGEN-1:0][RATIO_W-1:0] gratio,
   input logic [RATIO_W-1:0]           cpu_ratio
);
   logic [NSRC-1:0] edg;
   logic [NGEN-1:0] hit;

   assign edg = src_rise | src_fall;

   always_comb begin
      for (int i = 0; i < NGEN; i++) begin
         hit[i] = 1'b0;
         for (int s = 0; s < NSRC; s++)
            if (gsel[i] == SEL_W'(s)) hit[i] = edg[s];
      end
   end

   // R6: restart leaves every general and processor level low
   a_r6_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (gen_lvl == '0 && !cpu_lvl));

   // R7: processor ratio is always one of 1, 2, 4
   a_r7_cpu_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cpu_ratio) == 1 && cpu_ratio < RATIO_W'(8)));

   // R3: period strobe coincides with the level rising
   a_r3_cpu_stb_rise: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stb |-> $rose(cpu_lvl));
   a_r9_aux_stb_rise: assert property (@(posedge clk) disable iff (!rst_n)
      aux_stb |-> $rose(aux_lvl));

   genvar i, j;
   generate
      for (i = 0; i < NGEN; i++) begin : g_chk
         a_r3_stb_rise: assert property (@(posedge clk) disable iff (!rst_n)
            gen_stb[i] |-> $rose(gen_lvl[i]));

         // R10: no own-source edge and no write -> level holds
         a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_wr && !hit[i]) |=> $stable(gen_lvl[i]));

         for (j = i + 1; j < NGEN; j++) begin : g_pair
            // R6: same source and ratio give identical levels
            a_r6_pair_aligned: assert property (@(posedge clk) disable iff (!rst_n)
               (gsel[i] == gsel[j] && gratio[i] == gratio[j]) |-> (gen_lvl[i] == gen_lvl[j]));
         end
      end
   endgenerate
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
   .NSRC    (NSRC),
   .NGEN    (NGEN),
   .SEL_W   (SEL_W),
   .RATIO_W (clkdiv_pkg::RATIO_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_rise  (src_rise),
   .src_fall  (src_fall),
   .cfg_wr    (cfg_wr),
   .gen_lvl   (gen_lvl),
   .gen_stb   (gen_stb),
   .cpu_lvl   (cpu_lvl),
   .cpu_stb   (cpu_stb),
   .aux_lvl   (aux_lvl),
   .aux_stb   (aux_stb),
   .gsel      (gsel_q),
   .gratio    (gratio_q),
   .cpu_ratio (cpu_ratio_q)
);

// File: tb/tb_clkdiv_bank.sv
`timescale 1ns/1ps
module tb_clkdiv_bank;
   localparam int NSRC  = 3;
   localparam int NGEN  = 4;
   localparam int CFG_W = 37;
   localparam int NP    = NGEN + 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [NSRC-1:0]  src_rise;
   logic [NSRC-1:0]  src_fall;
   logic             cfg_wr;
   logic [CFG_W-1:0] cfg_img;
   logic [NGEN-1:0]  gen_lvl;
   logic [NGEN-1:0]  gen_stb;
   logic             cpu_lvl, cpu_stb, aux_lvl, aux_stb;

   always #10 clk = ~clk;

   clkdiv_bank dut (
      .clk(clk), .rst_n(rst_n), .src_rise(src_rise), .src_fall(src_fall),
      .cfg_wr(cfg_wr), .cfg_img(cfg_img), .gen_lvl(gen_lvl), .gen_stb(gen_stb),
      .cpu_lvl(cpu_lvl), .cpu_stb(cpu_stb), .aux_lvl(aux_lvl), .aux_stb(aux_stb)
   );

   int checks = 0;
   int errors = 0;
   string tag;

   int tb_ratio [18] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104};

   // reference state: 0..3 general, 4 processor, 5 auxiliary
   int m_n   [NP];
   int m_sel [NP];
   int m_p   [NP];
   bit m_run [NP];
   bit m_aft [NP];
   bit m_stb [NP];
   int aux_idx;
   bit nxt_fall [NSRC];

   function automatic bit exp_lvl(int k);
      if (!m_run[k]) return 1'b0;
      if (m_n[k] % 2 == 0) return m_p[k] < m_n[k] / 2;
      if (m_aft[k])        return m_p[k] < m_n[k] / 2;
      return m_p[k] <= m_n[k] / 2;
   endfunction

   function automatic bit got_lvl(int k);
      if (k < NGEN)  return gen_lvl[k];
      if (k == NGEN) return cpu_lvl;
      return aux_lvl;
   endfunction

   function automatic bit got_stb(int k);
      if (k < NGEN)  return gen_stb[k];
      if (k == NGEN) return cpu_stb;
      return aux_stb;
   endfunction

   function automatic string lvl_req(int k);
      if (k == NGEN)     return "R7";
      if (k == NGEN + 1) return "R9";
      return (m_n[k] % 2 == 1) ? "R5" : "R4";
   endfunction

   task automatic check_all();
      for (int k = 0; k < NP; k++) begin
         checks++;
         if (got_lvl(k) !== exp_lvl(k)) begin
            errors++;
            $display("FAIL %s %s path%0d N=%0d lvl got %0b exp %0b", tag, lvl_req(k), k, m_n[k], got_lvl(k), exp_lvl(k));
         end
         checks++;
         if (got_stb(k) !== m_stb[k]) begin
            errors++;
            $display("FAIL %s R3 path%0d N=%0d stb got %0b exp %0b", tag, k, m_n[k], got_stb(k), m_stb[k]);
         end
      end
   endtask

   function automatic void restart(int k);
      m_run[k] = 0; m_p[k] = 0; m_aft[k] = 0; m_stb[k] = 0;
   endfunction

   function automatic void model_step(bit wr, logic [CFG_W-1:0] img, logic [NSRC-1:0] r, logic [NSRC-1:0] f);
      bit rs [NP];
      for (int k = 0; k < NP; k++) rs[k] = 0;
      if (wr) begin
         for (int k = 0; k < NGEN; k++) begin
            int sel = int'(img[7*k +: 2]);
            int idx = int'(img[7*k+2 +: 5]);
            if (sel < NSRC) m_sel[k] = sel;
            if (idx < 18)   m_n[k] = tb_ratio[idx];
            rs[k] = 1;
         end
         begin
            int sel  = int'(img[28 +: 2]);
            int code = int'(img[30 +: 2]);
            if (sel < NSRC) m_sel[NGEN] = sel;
            if (code < 3)   m_n[NGEN] = 1 << code;
            rs[NGEN] = 1;
         end
         begin
            int idx = int'(img[32 +: 5]);
            if (idx < 18 && idx != aux_idx) begin
               aux_idx = idx;
               m_n[NGEN+1] = tb_ratio[idx];
               rs[NGEN+1] = 1;
            end
         end
      end
      for (int k = 0; k < NP; k++) begin
         if (rs[k]) restart(k);
         else begin
            int s = m_sel[k];
            m_stb[k] = 0;
            if (r[s]) begin
               m_p[k]   = m_run[k] ? (m_p[k] + 1) % m_n[k] : 0;
               m_run[k] = 1;
               m_aft[k] = 0;
               m_stb[k] = (m_p[k] == 0);
            end else if (f[s] && m_run[k]) begin
               m_aft[k] = 1;
            end
         end
      end
   endfunction

   // one cycle: check what the last stimulus produced, then drive new stimulus
   task automatic cycle(bit wr, logic [CFG_W-1:0] img, int edge_pct);
      logic [NSRC-1:0] r = '0;
      logic [NSRC-1:0] f = '0;
      @(negedge clk);
      check_all();
      for (int s = 0; s < NSRC; s++) begin
         if (($urandom % 100) < edge_pct) begin
            if (nxt_fall[s]) f[s] = 1'b1; else r[s] = 1'b1;
            nxt_fall[s] = ~nxt_fall[s];
         end
      end
      cfg_wr = wr; cfg_img = img; src_rise = r; src_fall = f;
      model_step(wr, img, r, f);
   endtask

   task automatic run(int n, int pct);
      for (int c = 0; c < n; c++) cycle(1'b0, cfg_img, pct);
   endtask

   function automatic logic [CFG_W-1:0] mk(int s0, int i0, int s1, int i1, int s2, int i2,
                                           int s3, int i3, int cs, int cc, int ai);
      logic [CFG_W-1:0] v = '0;
      v[1:0] = 2'(s0);   v[6:2]   = 5'(i0);
      v[8:7] = 2'(s1);   v[13:9]  = 5'(i1);
      v[15:14] = 2'(s2); v[20:16] = 5'(i2);
      v[22:21] = 2'(s3); v[27:23] = 5'(i3);
      v[29:28] = 2'(cs); v[31:30] = 2'(cc);
      v[36:32] = 5'(ai);
      return v;
   endfunction

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog expired got running exp finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2291));
      for (int k = 0; k < NP; k++) begin
         m_n[k] = 1; m_sel[k] = 0; restart(k);
      end
      aux_idx = 0;
      for (int s = 0; s < NSRC; s++) nxt_fall[s] = 0;
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_img = '0; src_rise = '0; src_fall = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, then divide-by-1 behaviour on source 0
      tag = "R1";
      run(12, 100);

      // R2: long odd/even ratios from the table, then rejected indices
      tag = "R2";
      cycle(1'b1, mk(0, 9, 0, 17, 1, 15, 2, 12, 0, 2, 4), 100);
      run(260, 100);
      cycle(1'b1, mk(0, 25, 0, 31, 1, 18, 2, 12, 0, 3, 30), 100);
      run(260, 100);

      // R8: out-of-range source selects are held
      tag = "R8";
      cycle(1'b1, mk(3, 2, 3, 4, 1, 0, 2, 7, 3, 1, 30), 100);
      run(120, 100);

      // R6: related ratios on one source stay aligned after a write
      tag = "R6";
      cycle(1'b1, mk(1, 1, 1, 3, 1, 6, 1, 1, 1, 2, 4), 70);
      run(150, 70);

      // R9: auxiliary restart only on a changed valid index
      tag = "R9";
      cycle(1'b1, mk(0, 2, 0, 2, 0, 2, 0, 2, 0, 0, 4), 60);
      run(40, 60);
      cycle(1'b1, mk(0, 4, 1, 2, 2, 9, 0, 5, 0, 1, 9), 60);
      run(200, 60);

      // R10: random images and sparse random edges
      tag = "R10";
      for (int rnd = 0; rnd < 24; rnd++) begin
         logic [CFG_W-1:0] img = {$urandom, $urandom};
         int pct = 20 + int'($urandom % 80);
         cycle(1'b1, img, pct);
         run(140, pct);
      end

      cycle(1'b0, cfg_img, 0);
      @(negedge clk);
      check_all();
      finish_run();
   end
endmodule